// File: doc/BRIEF.md
# Multi-Lane Elastic Deskew Buffer

This block sits behind the decoders of a multi-lane serial receiver. Each lane delivers decoded sample words with its own unknown delay, caused mostly by unequal board routing. Each lane has its own elastic FIFO. A lane starts storing words at the first word it sees flagged as the start of a multiframe. From that word on, the lane counts as ready.

Once every lane is ready, the block does not release data straight away. It waits for the next tick of the local multiframe clock, then waits a further programmable number of cycles. At that instant every FIFO starts reading in the same cycle. The same thing happens for every lane, so words that were sampled together leave the block together on one wide output bus.

If any lane loses its valid signal after release, the alignment is treated as lost. The block clears every FIFO and every ready flag, then waits for new start words to align again.

Top module: `lane_deskew_buffer`

## Requirements
- R1: A lane stores a word only when its valid input is high and either the start flag is high in that cycle or the lane has already stored its start word. Words that arrive before the start word are discarded.
- R2: After its start word, a lane stores every word whose valid input is high, in arrival order. The lane's ready flag stays set until the buffers are cleared.
- R3: The alignment starts with the block waiting for all lanes to be ready.
  - The block becomes armed two cycles after the latest start word has been accepted.
  - The first multiframe tick seen while armed fixes the release.
  - Output starts exactly relOffset+1 cycles after that tick.
  - A tick seen before arming has no effect.
- R4: Before release, outValid is low whatever the lane inputs do.
- R5: After release, the block shows the oldest word of every lane on outData and pulls it from every FIFO in the same cycle. Lane i occupies bits [i*DATA_W +: DATA_W]. outValid is high in each cycle that every lane holds data. Each output cycle carries, for every lane, the word with the same count since that lane's start word.
- R6: Before release, a write to a lane whose FIFO already holds DEPTH words is dropped. It also sets overflowErr from the next cycle. overflowErr then stays high until reset or until a loss of alignment clears the buffers.
- R7: If any lane's valid input is low while the block is released, the following happens at the next clock edge:
  - every FIFO is emptied and every ready flag is cleared;
  - the block goes back to waiting for start words;
  - outValid is low from the next cycle.
- R8: After reset, outValid and overflowErr are low and all FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneData | input | NUM_LANES*DATA_W | Decoded word per lane, lane i at bits [i*DATA_W +: DATA_W] |
| laneValid | input | NUM_LANES | Word valid per lane |
| laneSom | input | NUM_LANES | Start-of-multiframe flag per lane |
| mfTick | input | 1 | Local multiframe clock tick, one cycle wide |
| relOffset | input | OFF_W | Extra cycles between the chosen tick and release |
| outData | output | NUM_LANES*DATA_W | Aligned words of all lanes |
| outValid | output | 1 | outData carries an aligned word set |
| overflowErr | output | 1 | Sticky: a lane overflowed before release |

## Verification
The bench gives each lane a different start delay and tick pattern, and works out the exact release cycle from those values. A design that released on the first tick regardless of readiness, or that started reading as soon as each FIFO held data, would begin output in the wrong cycle or with mismatched sample counts across lanes. The bench tags every word with its lane and its count since the start word. Words sent before the start word carry a distinct marker, so a lane that stored them would show that marker at its output. The bench also overfills one lane while another never starts, and checks that overflowErr rises in the predicted cycle and then stays high. It drops one lane's valid input after release and checks three things: output stops in the next cycle, the error flag is clear, and a new alignment produces the same release cycle as one made from reset. A design that failed to flush on loss would output stale words.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic flush;   // empty every FIFO and clear ready flags
    logic run;     // released: reads allowed
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_WAIT_READY = 2'd0,
    ST_ARMED      = 2'd1,
    ST_HOLD       = 2'd2,
    ST_RUN        = 2'd3
  } alignState_t;
endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              full,
  output logic [LVL_W-1:0]  level
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              doWrite, doRead;

  assign empty   = (level == '0);
  assign full    = (level == LVL_W'(DEPTH));
  assign doRead  = rdEn && !empty;
  assign doWrite = wrEn && (!full || doRead);
  assign rdData  = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doWrite) wrPtr <= nextPtr(wrPtr);
      if (doRead)  rdPtr <= nextPtr(rdPtr);
      case ({doWrite, doRead})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));
endmodule

// File: rtl/deskew_datapath.sv
module deskew_datapath
  import deskew_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 16,
  localparam int BUS_W    = NUM_LANES * DATA_W,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [BUS_W-1:0]     laneData,
  input  logic [NUM_LANES-1:0] laneValid,
  input  logic [NUM_LANES-1:0] laneSom,
  output logic [NUM_LANES-1:0] laneReady,
  output logic [BUS_W-1:0]     outData,
  output logic                 outValid,
  output logic                 overflowErr
);
  logic [NUM_LANES-1:0] writing, wrEn, emptyV, fullV, overflowV;
  logic [LVL_W-1:0]     levelV [NUM_LANES];
  logic                 rdAll;

  assign rdAll     = strobes.run && !(|emptyV);
  assign outValid  = rdAll;
  assign laneReady = writing;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign wrEn[i] = laneValid[i] && (writing[i] || laneSom[i]) && !strobes.flush;
    assign overflowV[i] = wrEn[i] && fullV[i] && !rdAll;

    always_ff @(posedge clk) begin
      if (!rstN || strobes.flush) writing[i] <= 1'b0;
      else if (laneValid[i] && laneSom[i]) writing[i] <= 1'b1;
    end

    lane_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
      .clk    (clk),
      .rstN   (rstN),
      .flush  (strobes.flush),
      .wrEn   (wrEn[i]),
      .wrData (laneData[i*DATA_W +: DATA_W]),
      .rdEn   (rdAll),
      .rdData (outData[i*DATA_W +: DATA_W]),
      .empty  (emptyV[i]),
      .full   (fullV[i]),
      .level  (levelV[i])
    );

    // R1: nothing enters a lane before its start word
    a_r1_no_store_before_start: assert property (@(posedge clk) disable iff (!rstN)
      (levelV[i] == '0 && !writing[i] && !laneSom[i]) |=> levelV[i] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.flush) overflowErr <= 1'b0;
    else if (!strobes.run && |overflowV) overflowErr <= 1'b1;
  end

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflowErr && !strobes.flush) |=> overflowErr);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flush |=> (&emptyV && writing == '0 && !outValid));
endmodule

// File: rtl/deskew_control.sv
module deskew_control
  import deskew_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int OFF_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LANES-1:0] laneReady,
  input  logic [NUM_LANES-1:0] laneValid,
  input  logic                 mfTick,
  input  logic [OFF_W-1:0]     relOffset,
  output ctrlStrobes_t         strobes
);
  alignState_t state, stateNext;
  logic [OFF_W-1:0] holdCnt, holdCntNext;
  logic allReady, linkLost;

  assign allReady = &laneReady;
  assign linkLost = (state == ST_RUN) && !(&laneValid);
  assign strobes.flush = linkLost;
  assign strobes.run   = (state == ST_RUN);

  always_comb begin
    stateNext   = state;
    holdCntNext = holdCnt;
    unique case (state)
      ST_WAIT_READY: if (allReady) stateNext = ST_ARMED;
      ST_ARMED: if (mfTick) begin
        if (relOffset == '0) stateNext = ST_RUN;
        else begin
          stateNext   = ST_HOLD;
          holdCntNext = relOffset - 1'b1;
        end
      end
      ST_HOLD: begin
        if (holdCnt == '0) stateNext = ST_RUN;
        else holdCntNext = holdCnt - 1'b1;
      end
      ST_RUN: if (linkLost) stateNext = ST_WAIT_READY;
      default: stateNext = ST_WAIT_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_WAIT_READY;
      holdCnt <= '0;
    end else begin
      state   <= stateNext;
      holdCnt <= holdCntNext;
    end
  end

  a_r3_release_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.run) |-> allReady);

  a_r3_armed_by_ready: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_READY && !allReady) |=> state == ST_WAIT_READY);

  a_r7_loss_leaves_run: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && !(&laneValid)) |=> !strobes.run);
endmodule

// File: rtl/lane_deskew_buffer.sv
module lane_deskew_buffer
  import deskew_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 16,
  parameter int OFF_W     = 4,
  localparam int BUS_W    = NUM_LANES * DATA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BUS_W-1:0]     laneData,
  input  logic [NUM_LANES-1:0] laneValid,
  input  logic [NUM_LANES-1:0] laneSom,
  input  logic                 mfTick,
  input  logic [OFF_W-1:0]     relOffset,
  output logic [BUS_W-1:0]     outData,
  output logic                 outValid,
  output logic                 overflowErr
);
  ctrlStrobes_t         strobes;
  logic [NUM_LANES-1:0] laneReady;

  deskew_control #(.NUM_LANES(NUM_LANES), .OFF_W(OFF_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .laneReady (laneReady),
    .laneValid (laneValid),
    .mfTick    (mfTick),
    .relOffset (relOffset),
    .strobes   (strobes)
  );

  deskew_datapath #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .laneData    (laneData),
    .laneValid   (laneValid),
    .laneSom     (laneSom),
    .laneReady   (laneReady),
    .outData     (outData),
    .outValid    (outValid),
    .overflowErr (overflowErr)
  );

  a_r4_silent_before_release: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.run |-> !outValid);
endmodule

// File: tb/lane_deskew_buffer_tb_top.sv
module lane_deskew_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL    = 4;
  localparam int DW    = 16;
  localparam int DEPTH = 16;
  localparam int OW    = 4;
  localparam int NVEC  = 5;
  // vector: {d3,d2,d1,d0 (4b each), offset (4b), tick period (6b)}
  localparam logic [25:0] VECS [NVEC] = '{
    {4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 6'd4},
    {4'd5, 4'd1, 4'd3, 4'd0, 4'd2, 6'd4},
    {4'd0, 4'd4, 4'd7, 4'd2, 4'd5, 6'd5},
    {4'd3, 4'd2, 4'd6, 4'd6, 4'd1, 6'd3},
    {4'd1, 4'd1, 4'd1, 4'd9, 4'd3, 6'd2}
  };

  logic clk = 0, rstN = 0;
  logic [NL*DW-1:0] laneData = '0;
  logic [NL-1:0] laneValid = '0, laneSom = '0;
  logic mfTick = 0;
  logic [OW-1:0] relOffset = '0;
  logic [NL*DW-1:0] outData;
  logic outValid, overflowErr;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_deskew_buffer #(.NUM_LANES(NL), .DATA_W(DW), .DEPTH(DEPTH), .OFF_W(OW)) dut_i (
    .clk(clk), .rstN(rstN), .laneData(laneData), .laneValid(laneValid),
    .laneSom(laneSom), .mfTick(mfTick), .relOffset(relOffset),
    .outData(outData), .outValid(outValid), .overflowErr(overflowErr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 0; laneValid = '0; laneSom = '0; mfTick = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
  endtask

  // Drives one alignment case from the current point and checks release and data
  task automatic runCase(input logic [25:0] v);
    int d[NL];
    int off, per, maxd, t0, rel;
    logic [NL*DW-1:0] exp;
    for (int i = 0; i < NL; i++) d[i] = int'(v[10 + 4*i +: 4]);
    off = int'(v[9:6]); per = int'(v[5:0]);
    maxd = 0;
    for (int i = 0; i < NL; i++) if (d[i] > maxd) maxd = d[i];
    t0 = maxd + 2;
    while ((t0 % per) != per - 1) t0++;
    rel = t0 + off + 1;
    for (int t = 0; t <= rel + 8; t++) begin
      @(posedge clk); #1;
      relOffset = OW'(off);
      mfTick = ((t % per) == per - 1);
      for (int i = 0; i < NL; i++) begin
        laneValid[i] = 1'b1;
        laneSom[i]   = (t == d[i]);
        laneData[i*DW +: DW] = (t >= d[i]) ? {4'(i), 12'(t - d[i])} : {4'(i), 12'hEEE};
      end
      @(negedge clk);
      if (t < rel) check("R3/R4 no output before release", 64'(outValid), 64'd0);
      else begin
        for (int i = 0; i < NL; i++) exp[i*DW +: DW] = {4'(i), 12'(t - rel)};
        check("R3 release cycle", 64'(outValid), 64'd1);
        check("R1/R2/R5 aligned data", 64'(outData), 64'(exp));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    @(negedge clk);
    // R8 reset state
    check("R8 outValid after reset", 64'(outValid), 64'd0);
    check("R8 overflowErr after reset", 64'(overflowErr), 64'd0);

    for (int k = 0; k < NVEC; k++) begin
      doReset();
      runCase(VECS[k]);
    end

    // R7: loss of valid after release, then realignment without reset
    @(posedge clk); #1 laneValid[2] = 1'b0; laneSom = '0;
    @(posedge clk); #1 laneValid = '1;
    @(negedge clk);
    check("R7 outValid low after loss", 64'(outValid), 64'd0);
    check("R7 overflowErr clear after loss", 64'(overflowErr), 64'd0);
    repeat (3) begin
      @(negedge clk);
      check("R7 stays idle without start", 64'(outValid), 64'd0);
    end
    runCase(VECS[1]);

    // R6: overflow on lane 0 while other lanes never start
    doReset();
    for (int t = 0; t <= DEPTH + 4; t++) begin
      @(posedge clk); #1;
      laneValid = '1;
      laneSom = (t == 0) ? 4'b0001 : 4'b0000;
      mfTick = 1'b1;
      @(negedge clk);
      if (t == DEPTH) check("R6 no error at exactly full", 64'(overflowErr), 64'd0);
      if (t == DEPTH + 1) check("R6 error after write to full", 64'(overflowErr), 64'd1);
      if (t == DEPTH + 4) check("R6 error sticky", 64'(overflowErr), 64'd1);
      check("R4 no output while lanes missing", 64'(outValid), 64'd0);
    end
    doReset();
    @(negedge clk);
    check("R8 reset clears overflowErr", 64'(overflowErr), 64'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule